// File: doc/BRIEF.md
# SDRAM Mode Register Command Unit

This block lives on the device side of a single-data-rate SDRAM command bus. On every rising clock edge it samples clock enable, chip select, the three strobes (RAS, CAS, WE), a two-bit bank selector and the address bus. From these it picks out the mode-programming command. The command writes one of two registers: a normal register that holds the CAS latency, burst length, burst ordering and write-burst mode, and an extended register that holds the self-refresh coverage and the output driver strength. The bank selector chooses which register is written.

A write is accepted only if every bank is closed and no earlier write is still in its settling window. The register code must also be legal. If any of these conditions fails, the stored values stay as they were and a one-cycle illegal pulse is raised. The decoded fields appear on plain outputs, which the read/write datapath and the refresh logic use directly.

Top module: `sdram_mode_unit`

## Requirements
- R1: A register write command is recognised only when, at a rising edge, cke=1 and cs_n, ras_n, cas_n and we_n are all 0. Any other combination leaves every output unchanged and keeps `illegal` low.
- R2: bank=00 addresses the normal register and bank=10 addresses the extended register. A write with bank=01 or bank=11 is refused, and it leaves both registers untouched.
- R3: Normal register addr[2:0] sets `burst_words`: 000→1, 001→2, 010→4, 011→8, and 111→PAGE_WORDS. Code 111 is legal only when addr[3]=0. Codes 100, 101 and 110 are refused.
- R4: Normal register addr[3] drives `burst_ilv`: 0 selects sequential order and 1 selects interleaved order.
- R5: Normal register addr[6:4] sets `cas_lat`: 001→1, 010→2, 011→3. Every other code is refused. The write is also refused if addr[8:7] is not 00 or if any of addr[AW-1:10] is set. The same check on addr[AW-1:10] applies to extended writes.
- R6: Normal register addr[9] drives `single_wr`: when it is 1, writes transfer one word while reads keep the programmed burst.
- R7: Extended register addr[2:0] sets `pasr_sel`: 000→0 (full array), 001→1 (half), 010→2 (quarter). addr[6:5] sets `drv_half`: 00→0 (full strength), 01→1 (half strength). Any other code in either field is refused.
- R8: A write is refused while any bit of `open_banks` is 1.
- R9: After a write is accepted, write commands at the next LOCK_CYC rising edges are refused. The first write after that window may be accepted.
- R10: A refused write raises `illegal` for exactly the one cycle after its edge, and it changes no output field. Every output field updates in the cycle after the edge that accepted the write.
- R11: Reset (rst_n=0) gives cas_lat=3, burst_words=1, burst_ilv=0, single_wr=0, pasr_sel=0, drv_half=0 and illegal=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable sampled with the command |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| bank | input | 2 | Register selector during a write |
| addr | input | AW | Op-code bits |
| open_banks | input | NBANK | One bit per bank, 1 while that bank's row is open |
| cas_lat | output | 2 | Decoded CAS latency, 1 to 3 |
| burst_words | output | $clog2(PAGE_WORDS+1) | Burst length in words |
| burst_ilv | output | 1 | 1 when bursts use interleaved order |
| single_wr | output | 1 | 1 when writes are single-word |
| pasr_sel | output | 2 | Self-refresh coverage: 0 full, 1 half, 2 quarter |
| drv_half | output | 1 | 1 when the output driver is at half strength |
| illegal | output | 1 | One-cycle pulse for a refused write |

## Verification
The bench builds the block with PAGE_WORDS=512 and LOCK_CYC=3. The page width therefore differs from the default, and the full-page code must follow the parameter and not a fixed constant. The longer lockout makes refused attempts possible at each of three consecutive edges, and the edge right after the window can then be shown to accept. A long stretch of mixed commands checks the counter against open banks, reserved codes and back-to-back writes.

// File: rtl/sdram_mode_unit.sv
module sdram_mode_unit #(
  parameter int NBANK = 4,
  parameter int AW = 13,
  parameter int PAGE_WORDS = 1024,
  parameter int LOCK_CYC = 2,
  localparam int BW = $clog2(PAGE_WORDS + 1),
  localparam int LW = $clog2(LOCK_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [1:0]       bank,
  input  logic [AW-1:0]    addr,
  input  logic [NBANK-1:0] open_banks,
  output logic [1:0]       cas_lat,
  output logic [BW-1:0]    burst_words,
  output logic             burst_ilv,
  output logic             single_wr,
  output logic [1:0]       pasr_sel,
  output logic             drv_half,
  output logic             illegal
);

  logic [2:0]    bl_code;
  logic          bt_q;
  logic [1:0]    cl_q;
  logic          sw_q;
  logic [1:0]    pasr_q;
  logic          ds_q;
  logic [LW-1:0] lock;

  wire wr_cmd = cke & ~cs_n & ~ras_n & ~cas_n & ~we_n;
  wire sel_n  = (bank == 2'b00);
  wire sel_e  = (bank == 2'b10);
  wire rfu_ok = ~|addr[AW-1:10];

  wire bl_ok  = ~addr[2] | (addr[2:0] == 3'b111 & ~addr[3]);
  wire cl_ok  = ~addr[6] & (addr[5:4] != 2'b00);
  wire nrm_ok = bl_ok & cl_ok & (addr[8:7] == 2'b00);
  wire ext_ok = ~addr[2] & (addr[1:0] != 2'b11) & ~addr[6];

  wire code_ok = rfu_ok & ((sel_n & nrm_ok) | (sel_e & ext_ok));
  wire accept  = wr_cmd & code_ok & ~|open_banks & (lock == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bl_code <= 3'b000;
      bt_q    <= 1'b0;
      cl_q    <= 2'd3;
      sw_q    <= 1'b0;
      pasr_q  <= 2'd0;
      ds_q    <= 1'b0;
      lock    <= '0;
      illegal <= 1'b0;
    end else begin
      illegal <= wr_cmd & ~accept;
      if (accept & sel_n) begin
        bl_code <= addr[2:0];
        bt_q    <= addr[3];
        cl_q    <= addr[5:4];
        sw_q    <= addr[9];
      end
      if (accept & sel_e) begin
        pasr_q <= addr[1:0];
        ds_q   <= addr[5];
      end
      if (accept)
        lock <= LW'(LOCK_CYC);
      else if (lock != '0)
        lock <= lock - 1'b1;
    end
  end

  assign cas_lat     = cl_q;
  assign burst_words = (bl_code == 3'b111) ? BW'(PAGE_WORDS) : (BW'(1) << bl_code[1:0]);
  assign burst_ilv   = bt_q;
  assign single_wr   = sw_q;
  assign pasr_sel    = pasr_q;
  assign drv_half    = ds_q;

endmodule

module sdram_mode_unit_chk #(
  parameter int NBANK = 4,
  parameter int PAGE_WORDS = 1024,
  parameter int LOCK_CYC = 2,
  localparam int BW = $clog2(PAGE_WORDS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [NBANK-1:0] open_banks,
  input logic [1:0]       cas_lat,
  input logic [BW-1:0]    burst_words,
  input logic             burst_ilv,
  input logic             single_wr,
  input logic [1:0]       pasr_sel,
  input logic             drv_half,
  input logic             illegal
);
  localparam int CW = BW + 7;
  wire [CW-1:0] cfg = {cas_lat, burst_words, burst_ilv, single_wr, pasr_sel, drv_half};
  logic [CW-1:0] cfg_q;
  int since;
  wire chg = (cfg != cfg_q);
  wire is_wr = cke & ~cs_n & ~ras_n & ~cas_n & ~we_n;

  always_ff @(posedge clk) begin
    cfg_q <= cfg;
    if (!rst_n) since <= LOCK_CYC;
    else if (chg) since <= 0;
    else if (since < LOCK_CYC) since <= since + 1;
  end

  // R1
  cmd_only_chk: assert property (@(posedge clk) disable iff (!rst_n) chg |-> $past(is_wr));
  // R8
  banks_closed_chk: assert property (@(posedge clk) disable iff (!rst_n) chg |-> $past(open_banks) == '0);
  // R9
  lockout_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) chg |-> since >= LOCK_CYC);
  // R10
  refused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> !chg);
  // R3
  page_seq_chk: assert property (@(posedge clk) disable iff (!rst_n) burst_words == BW'(PAGE_WORDS) |-> !burst_ilv);
  // R3
  burst_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n) $countones(burst_words) == 1);
  // R5
  cl_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cas_lat != 2'd0);
  // R7
  pasr_range_chk: assert property (@(posedge clk) disable iff (!rst_n) pasr_sel != 2'd3);
endmodule

bind sdram_mode_unit sdram_mode_unit_chk #(.NBANK(NBANK), .PAGE_WORDS(PAGE_WORDS), .LOCK_CYC(LOCK_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .open_banks(open_banks), .cas_lat(cas_lat), .burst_words(burst_words), .burst_ilv(burst_ilv),
  .single_wr(single_wr), .pasr_sel(pasr_sel), .drv_half(drv_half), .illegal(illegal)
);

// File: tb/tb_sdram_mode_unit.sv
`timescale 1ns/100ps
module tb_sdram_mode_unit;
  localparam int NB = 4, AW = 13, PW = 512, LK = 3;
  localparam int BW = $clog2(PW + 1);

  logic clk = 0, rst_n = 0;
  logic cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0] bank = 0;
  logic [AW-1:0] addr = 0;
  logic [NB-1:0] open_banks = 0;
  logic [1:0] cas_lat, pasr_sel;
  logic [BW-1:0] burst_words;
  logic burst_ilv, single_wr, drv_half, illegal;

  int checks = 0, fails = 0;
  int m_cl, m_bl, m_bt, m_sw, m_pasr, m_ds, m_ill, m_lock;
  bit done = 0;

  sdram_mode_unit #(.NBANK(NB), .AW(AW), .PAGE_WORDS(PW), .LOCK_CYC(LK)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int blc, clc, pc, dc;
    bit cmd, ok, go;
    if (!rst_n) begin
      m_cl <= 3; m_bl <= 1; m_bt <= 0; m_sw <= 0; m_pasr <= 0; m_ds <= 0; m_ill <= 0; m_lock <= 0;
    end else begin
      cmd = cke && !cs_n && !ras_n && !cas_n && !we_n;
      blc = int'(addr[2:0]); clc = int'(addr[6:4]); pc = int'(addr[2:0]); dc = int'(addr[6:5]);
      ok = 0;
      if (addr[12:10] == 0) begin
        if (bank == 2'b00)
          ok = (blc < 4 || (blc == 7 && addr[3] == 0)) && clc >= 1 && clc <= 3 && addr[8:7] == 0;
        else if (bank == 2'b10)
          ok = pc <= 2 && dc <= 1;
      end
      go = cmd && ok && open_banks == 0 && m_lock == 0;
      m_ill <= cmd && !go;
      if (go && bank == 2'b00) begin
        m_cl <= clc; m_bl <= (blc == 7) ? PW : (1 << blc); m_bt <= int'(addr[3]); m_sw <= int'(addr[9]);
      end
      if (go && bank == 2'b10) begin
        m_pasr <= pc; m_ds <= dc;
      end
      m_lock <= go ? LK : (m_lock > 0 ? m_lock - 1 : 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cas_lat == m_cl, "R5 cas_lat", cas_lat, m_cl);
      chk(burst_words == m_bl, "R3 burst_words", burst_words, m_bl);
      chk(burst_ilv == m_bt, "R4 burst_ilv", burst_ilv, m_bt);
      chk(single_wr == m_sw, "R6 single_wr", single_wr, m_sw);
      chk(pasr_sel == m_pasr && drv_half == m_ds, "R7 ext fields", {pasr_sel, drv_half}, m_pasr * 2 + m_ds);
      chk(illegal == m_ill, "R10 illegal", illegal, m_ill);
    end
  end

  task automatic nop();
    cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; open_banks = 0;
  endtask

  task automatic cmd(input bit k, input bit c, input bit r, input bit a, input bit w,
                     input [1:0] b, input [AW-1:0] ad, input [NB-1:0] ob);
    cke = k; cs_n = c; ras_n = r; cas_n = a; we_n = w; bank = b; addr = ad; open_banks = ob;
    @(negedge clk);
    nop();
  endtask

  task automatic wr(input [1:0] b, input [AW-1:0] ad);
    cmd(1, 0, 0, 0, 0, b, ad, '0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R11 reset values
    chk(cas_lat == 3 && burst_words == 1 && !burst_ilv && !single_wr && pasr_sel == 0 && !drv_half && !illegal,
        "R11 reset", {cas_lat, burst_words}, 3 * 1024 + 1);
    wr(2'b00, 13'h22B);
    chk(cas_lat == 2 && burst_words == 8, "R3 R5 write", {cas_lat, burst_words}, 2 * 1024 + 8);
    chk(burst_ilv && single_wr, "R4 R6 write", {burst_ilv, single_wr}, 3);
    idle(LK);
    cmd(0, 0, 0, 0, 0, 2'b00, 13'h010, '0);
    chk(cas_lat == 2 && !illegal, "R1 cke low", cas_lat, 2);
    cmd(1, 0, 0, 1, 0, 2'b00, 13'h010, '0);
    chk(cas_lat == 2 && !illegal, "R1 strobe mismatch", cas_lat, 2);
    wr(2'b00, 13'h010);
    chk(cas_lat == 1, "R9 first accepted", cas_lat, 1);
    wr(2'b00, 13'h030);
    chk(illegal && cas_lat == 1, "R9 lockout edge 1", cas_lat, 1);
    wr(2'b00, 13'h030);
    wr(2'b00, 13'h030);
    chk(illegal && cas_lat == 1, "R9 lockout edge 3", cas_lat, 1);
    wr(2'b00, 13'h030);
    chk(!illegal && cas_lat == 3, "R9 after window", cas_lat, 3);
    idle(LK);
    wr(2'b00, 13'h037);
    chk(burst_words == PW && !burst_ilv, "R3 full page", burst_words, PW);
    idle(LK);
    wr(2'b00, 13'h03F);
    chk(illegal && burst_words == PW && !burst_ilv, "R3 page interleave refused", burst_words, PW);
    wr(2'b00, 13'h000);
    chk(illegal && cas_lat == 3, "R5 latency 0 refused", cas_lat, 3);
    wr(2'b00, 13'h040);
    chk(illegal && cas_lat == 3, "R5 latency 4 refused", cas_lat, 3);
    wr(2'b00, 13'h110);
    chk(illegal && cas_lat == 3, "R5 A8 refused", cas_lat, 3);
    wr(2'b00, 13'h1010);
    chk(illegal && cas_lat == 3, "R5 A12 refused", cas_lat, 3);
    wr(2'b00, 13'h034);
    chk(illegal && burst_words == PW, "R3 code 100 refused", burst_words, PW);
    wr(2'b01, 13'h010);
    chk(illegal && cas_lat == 3 && pasr_sel == 0, "R2 bank 01", cas_lat, 3);
    wr(2'b11, 13'h001);
    chk(illegal && pasr_sel == 0, "R2 bank 11", pasr_sel, 0);
    wr(2'b10, 13'h022);
    chk(pasr_sel == 2 && drv_half && cas_lat == 3 && burst_words == PW, "R7 R2 extended", pasr_sel, 2);
    idle(LK);
    wr(2'b10, 13'h003);
    chk(illegal && pasr_sel == 2, "R7 pasr 3 refused", pasr_sel, 2);
    wr(2'b10, 13'h040);
    chk(illegal && drv_half, "R7 strength 10 refused", drv_half, 1);
    cmd(1, 0, 0, 0, 0, 2'b00, 13'h020, 4'b0100);
    chk(illegal && cas_lat == 3, "R8 open bank", cas_lat, 3);
    idle(2);
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [1:0] b;
      int r;
      r = $urandom_range(0, 9);
      a = AW'($urandom);
      if ($urandom_range(0, 3) != 0) a[12:10] = 0;
      if ($urandom_range(0, 3) != 0) a[8:7] = 0;
      b = 2'($urandom);
      if (r < 5)
        cmd(1, 0, 0, 0, 0, b, a, ($urandom_range(0, 4) == 0) ? NB'($urandom) : '0);
      else if (r < 6)
        cmd(0, 0, 0, 0, 0, b, a, '0);
      else if (r < 8)
        cmd(1, 1'($urandom), 1'($urandom), 1'($urandom), 1, b, a, NB'($urandom));
      else
        idle(1);
    end
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule